// File: doc/BRIEF.md
# Latching Watchdog Timer

This block checks that a processor is still alive. The processor toggles a kick line. Either a rising or a falling edge on that line counts as service. The timer is tied to the channel-one reset of a supply supervisor, and it does nothing while that reset is asserted. Once the reset is released, the timer counts time in prescaled ticks. If a full timeout interval passes with no kick edge, the active-low watchdog flag goes low.

The low flag is latched. Kicks that arrive after the timeout do not raise it again. The only thing that clears it is a new assertion of the supervisor reset, whatever caused that assertion: a manual reset, an undervoltage or a power cycle. The tick period is set in clock cycles and the timeout in ticks. A system clock with a 1 ms tick and 610 ticks gives the nominal interval; a bench can use much shorter values.

The kick line is asynchronous and passes through a flop synchroniser. The supervisor reset status and the power-on reset are treated as synchronous to the clock.

Top module: `latching_watchdog`

## Requirements
- R1: While the synchronous power-on reset `rst_n` is low, `wd_n` is high on the following clock. This holds even when a timeout was latched before.
- R2: While `sup_rst_n` is low, `wd_n` stays high no matter how long it is held low.
- R3: When `sup_rst_n` is high at a clock edge for the first time, counting starts. If no kick edge follows, `wd_n` is still high on edge `TIMEOUT_TICKS*CLKS_PER_TICK - 1` after the last edge that saw `sup_rst_n` low, and it is low on edge `TIMEOUT_TICKS*CLKS_PER_TICK`.
- R4: A rising edge on `kick` restarts the count. The restart takes effect at the third clock edge after the change: two synchroniser flops, then the edge-detect register. `wd_n` then falls `TIMEOUT_TICKS*CLKS_PER_TICK` edges after that third edge.
- R5: A falling edge on `kick` restarts the count in the same way as a rising edge, with the same latency.
- R6: If kick edges arrive more often than the timeout interval, `wd_n` stays high indefinitely.
- R7: Once `wd_n` is low, it stays low whatever happens on `kick`, for as long as `sup_rst_n` stays high.
- R8: A latched timeout clears only when `sup_rst_n` is asserted low. `wd_n` is high at the first clock edge that sees `sup_rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| sup_rst_n | input | 1 | Channel-one supervisor reset status, low means asserted |
| kick | input | 1 | Asynchronous service line from the processor; both edges count |
| wd_n | output | 1 | Watchdog flag, low after a timeout, latched |

## Verification
The bench drives four kinds of input pattern:
- An unkicked run after the supervisor reset is released. This pins down the exact timeout edge and separates a correct tick count from one that is off by a tick or a cycle.
- A single rising kick and a single falling kick, each placed halfway through the interval. A missed edge polarity shows up as a fall at the original deadline.
- A train of kicks shorter than the interval, which keeps the flag high, followed by silence. This tells a working restart apart from a counter that is merely slow.
- Kicks toggled after a timeout, followed by supervisor-reset and power-on-reset pulses. These separate a sticky latch from a plain comparator, and a correct clearing condition from one that also clears on a kick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      WDS_RUN  = 1'b0,
      WDS_TRIP = 1'b1
   } wd_state_e;

   function automatic int safe_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic edge_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], kick_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   // Either polarity of transition counts as service.
   assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int CLKS_PER_TICK = 50000,
   parameter int PW            = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic tick_o
);
   generate
      if (CLKS_PER_TICK == 1) begin : g_direct
         logic unused_direct;
         assign unused_direct = &{1'b0, clk, rst_n};
         assign tick_o        = !clr_i;
      end else begin : g_prescale
         localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);
         logic [PW-1:0] pcnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr_i)   pcnt_q <= '0;
            else if (pcnt_q == LAST) pcnt_q <= '0;
            else                   pcnt_q <= pcnt_q + 1'b1;
         end

         assign tick_o = (pcnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/wdt_tmo_count.sv
module wdt_tmo_count
   import wdt_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 610,
   parameter int CW            = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          kick_i,
   input  logic          tick_i,
   output logic [CW-1:0] cnt_o,
   output logic          trip_o
);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

   wd_state_e     st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) begin
         st_q  <= WDS_RUN;
         cnt_q <= '0;
      end else if (st_q == WDS_TRIP) begin
         st_q  <= WDS_TRIP;          // sticky until the supervisor resets
      end else if (kick_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (cnt_q == LAST) st_q  <= WDS_TRIP;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign trip_o = (st_q == WDS_TRIP);
endmodule

// File: rtl/latching_watchdog.sv
module latching_watchdog
   import wdt_pkg::*;
#(
   parameter int CLKS_PER_TICK = 50000,
   parameter int TIMEOUT_TICKS = 610,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_rst_n,
   input  logic kick,
   output logic wd_n
);
   localparam int PW = safe_width(CLKS_PER_TICK);
   localparam int CW = safe_width(TIMEOUT_TICKS + 1);

   generate
      if (CLKS_PER_TICK < 1)  begin : g_bad_tick  $error("CLKS_PER_TICK must be >= 1"); end
      if (TIMEOUT_TICKS < 1)  begin : g_bad_tmo   $error("TIMEOUT_TICKS must be >= 1"); end
      if (SYNC_STAGES < 2)    begin : g_bad_sync  $error("SYNC_STAGES must be >= 2");   end
   endgenerate

   logic          kick_edge;
   logic          tick;
   logic          trip;
   logic [CW-1:0] tick_cnt;

   wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (kick),
      .edge_o (kick_edge)
   );

   wdt_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK), .PW(PW)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (!sup_rst_n || kick_edge),
      .tick_o (tick)
   );

   wdt_tmo_count #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (sup_rst_n),
      .kick_i (kick_edge),
      .tick_i (tick),
      .cnt_o  (tick_cnt),
      .trip_o (trip)
   );

   assign wd_n = !trip;
endmodule

// File: rtl/latching_watchdog_chk.sv
module latching_watchdog_chk #(
   parameter int TIMEOUT_TICKS = 610,
   parameter int CW            = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sup_rst_n,
   input logic          wd_n,
   input logic          kick_edge,
   input logic [CW-1:0] tick_cnt
);
   localparam logic [CW-1:0] LIM = CW'(TIMEOUT_TICKS - 1);

   p_hold_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_rst_n |=> wd_n);

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt <= LIM);

   p_fall_when_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_n) |-> $past(sup_rst_n));

   p_kick_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kick_edge && sup_rst_n && wd_n) |=> (tick_cnt == '0));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_n && sup_rst_n) |=> !wd_n);

   p_clear_only_by_sup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_n) |-> $past(!sup_rst_n));
endmodule

bind latching_watchdog latching_watchdog_chk #(
   .TIMEOUT_TICKS (TIMEOUT_TICKS),
   .CW            (CW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sup_rst_n (sup_rst_n),
   .wd_n      (wd_n),
   .kick_edge (kick_edge),
   .tick_cnt  (tick_cnt)
);

// File: tb/latching_watchdog_bench.sv
`timescale 1ns/1ps
module latching_watchdog_bench;
   localparam int C    = 4;
   localparam int T    = 5;
   localparam int TPER = C * T;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup_rst_n = 1'b0;
   logic kick = 1'b0;
   logic wd_n;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int    q_cyc[$];
   bit    q_val[$];
   string q_tag[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   latching_watchdog #(.CLKS_PER_TICK(C), .TIMEOUT_TICKS(T), .SYNC_STAGES(2)) u_latching_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_rst_n (sup_rst_n),
      .kick      (kick),
      .wd_n      (wd_n)
   );

   task automatic expect_at(input int delta, input bit val, input string tag);
      q_cyc.push_back(cyc + delta);
      q_val.push_back(val);
      q_tag.push_back(tag);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares scoreboard entries as their cycle arrives
   always @(negedge clk) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
         total++;
         if (q_cyc[0] != cyc || wd_n !== q_val[0]) begin
            bad++;
            $display("FAIL %s cyc=%0d wd_n actual=%b expected=%b", q_tag[0], cyc, wd_n, q_val[0]);
         end
         void'(q_cyc.pop_front());
         void'(q_val.pop_front());
         void'(q_tag.pop_front());
      end
   end

   always @(negedge clk) begin
      if (cyc >= 5000 && !done) begin
         total++;
         bad++;
         $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(1);
      // R1: reset state
      expect_at(1, 1'b1, "R1");
      step(3);
      rst_n = 1'b1;
      // R2: held in supervisor reset far beyond the timeout
      expect_at(TPER + 2, 1'b1, "R2");
      expect_at(2 * TPER + 5, 1'b1, "R2");
      step(3 * TPER);
      // R3: release, no kicks
      sup_rst_n = 1'b1;
      expect_at(TPER - 1, 1'b1, "R3");
      expect_at(TPER, 1'b0, "R3");
      step(TPER + 3);
      // R7: kicks after timeout do not clear
      kick = 1'b1;
      expect_at(5, 1'b0, "R7");
      step(6);
      kick = 1'b0;
      expect_at(5, 1'b0, "R7");
      step(6);
      // R8: supervisor reset clears the latch
      sup_rst_n = 1'b0;
      expect_at(1, 1'b1, "R8");
      step(3);
      // R4: rising kick restarts the count
      sup_rst_n = 1'b1;
      step(10);
      kick = 1'b1;
      expect_at(10, 1'b1, "R4");
      expect_at(3 + TPER - 1, 1'b1, "R4");
      expect_at(3 + TPER, 1'b0, "R4");
      step(TPER + 5);
      sup_rst_n = 1'b0;
      expect_at(1, 1'b1, "R8");
      step(3);
      // R5: falling kick restarts the count
      sup_rst_n = 1'b1;
      step(10);
      kick = 1'b0;
      expect_at(10, 1'b1, "R5");
      expect_at(3 + TPER - 1, 1'b1, "R5");
      expect_at(3 + TPER, 1'b0, "R5");
      step(TPER + 5);
      sup_rst_n = 1'b0;
      step(3);
      // R6: regular kicks keep the flag high, then silence trips it
      sup_rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         step(12);
         kick = ~kick;
         expect_at(6, 1'b1, "R6");
      end
      expect_at(3 + TPER - 1, 1'b1, "R6");
      expect_at(3 + TPER, 1'b0, "R6");
      step(TPER + 5);
      // R1: power-on reset also clears a latched timeout
      rst_n = 1'b0;
      expect_at(1, 1'b1, "R1");
      step(3);
      rst_n = 1'b1;
      step(3);
      if (q_cyc.size() != 0) begin
         total++;
         bad++;
         $display("FAIL scoreboard actual=%0d pending expected=0", q_cyc.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule